// File: doc/BRIEF.md
# Triplicated Configuration Column with Serial Access

This block holds the configuration of one column of pixels in a readout chip. Configuration words travel through an ordinary serial shift register. A load strobe copies the whole register, in parallel, into a protected store. The store keeps every bit as three copies and drives the pixels with the bitwise majority of those copies. A readback strobe copies the voted store back into the shift register, so the contents can be shifted out and compared with what was written.

On every clock without a load, each bit's three copies are rewritten with their voted value. A single flipped copy is therefore repaired on the next edge, and the pixel outputs never see it. Whenever a disagreeing triplet is found, a one-cycle error pulse is raised. An upset-injection port can flip one chosen copy of one chosen bit. It models a radiation hit, so the correction path can be exercised.

The default size is 32 pixels of 8 bits each. That gives 256 protected bits and 256 shift flip-flops.

Top module: `cfg_column_tmr`

## Requirements
- R1: A synchronous reset clears every stored copy, every shift flip-flop and the error pulse, so `cfg_out`, `ser_out` and `err_pulse` read zero.
- R2: Each clock with `shift_en` high (and `readback` low) moves the shift register one place toward its top bit and takes `ser_in` into bit 0. `ser_out` is always the top bit, so a word shifted in top bit first occupies the register in order after `TOTAL_BITS` shifts.
- R3: With `shift_en`, `readback` and `rst` low, the shift register, and hence `ser_out`, keeps its value.
- R4: A clock with `load` high writes shift-register bit i into all three copies of stored bit i. `cfg_out[i]` shows it from the next cycle.
- R5: `cfg_out` changes only on the cycle after a load or a reset.
- R6: A clock with `readback` high puts the voted stored value into the shift register in parallel, taking priority over shifting. The bits then leave at `ser_out`, top bit first.
- R7: One flipped copy of a bit never changes `cfg_out`. The triplet is rewritten with its voted value on the next clock, so later readbacks return the loaded data.
- R8: `err_pulse` is high for exactly one cycle, two clocks after the clock on which a single upset was injected, and is otherwise low.
- R9: On a clock with `upset_en` high, `upset_copy` value 0, 1 or 2 inverts that copy of stored bit `upset_idx`. Value 3 changes nothing.
- R10: When `load` and `readback` share a clock, the store takes the old shift-register contents and the shift register takes the old voted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift one place this clock |
| ser_in | input | 1 | Serial data into bit 0 |
| ser_out | output | 1 | Serial data from the top bit |
| load | input | 1 | Copy shift register into the triplicated store |
| readback | input | 1 | Copy voted store into the shift register |
| upset_en | input | 1 | Inject one copy flip this clock |
| upset_copy | input | 2 | Copy to flip (0..2; 3 = none) |
| upset_idx | input | IDX_W | Bit position to flip |
| cfg_out | output | TOTAL_BITS | Voted configuration bits |
| err_pulse | output | 1 | One-cycle pulse after a disagreeing triplet |

## Verification
The assertions assume that upsets arrive at most one per clock. Under that assumption, a disagreeing triplet is always repaired on the next edge and the majority is never outvoted. They also assume the error pulse can only stem from an injection two clocks earlier. The bench keeps to this by injecting one flip and then idling for at least two clocks, sweeping every copy and every bit index of a 32-bit column. It always leaves `upset_idx` inside the column.

// File: rtl/cfg_column_tmr.sv
module cfg_column_tmr #(
  parameter int NUM_PIXELS = 32,
  parameter int PIXEL_BITS = 8,
  localparam int TOTAL_BITS = NUM_PIXELS * PIXEL_BITS,
  localparam int IDX_W = (TOTAL_BITS > 1) ? $clog2(TOTAL_BITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  logic                  ser_in,
  output logic                  ser_out,
  input  logic                  load,
  input  logic                  readback,
  input  logic                  upset_en,
  input  logic [1:0]            upset_copy,
  input  logic [IDX_W-1:0]      upset_idx,
  output logic [TOTAL_BITS-1:0] cfg_out,
  output logic                  err_pulse
);

  logic [TOTAL_BITS-1:0] chain;
  logic [TOTAL_BITS-1:0] copy_a, copy_b, copy_c;
  logic [TOTAL_BITS-1:0] voted, base, hit;
  logic                  mismatch;

  assign voted    = (copy_a & copy_b) | (copy_a & copy_c) | (copy_b & copy_c);
  assign mismatch = |((copy_a ^ copy_b) | (copy_a ^ copy_c));
  assign base     = load ? chain : voted;
  assign hit      = {{(TOTAL_BITS-1){1'b0}}, upset_en} << upset_idx;
  assign cfg_out  = voted;
  assign ser_out  = chain[TOTAL_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      copy_a    <= '0;
      copy_b    <= '0;
      copy_c    <= '0;
      chain     <= '0;
      err_pulse <= 1'b0;
    end else begin
      copy_a    <= base ^ ((upset_copy == 2'd0) ? hit : '0);
      copy_b    <= base ^ ((upset_copy == 2'd1) ? hit : '0);
      copy_c    <= base ^ ((upset_copy == 2'd2) ? hit : '0);
      err_pulse <= mismatch;
      if (readback)
        chain <= voted;
      else if (shift_en)
        chain <= {chain[TOTAL_BITS-2:0], ser_in};
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cfg_out == '0 && !ser_out && !err_pulse)); // R1
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst) (shift_en && !readback) |=> ser_out == $past(chain[TOTAL_BITS-2])); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst) (!shift_en && !readback) |=> $stable(chain)); // R3
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst) load |=> cfg_out == $past(chain)); // R4
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(cfg_out)); // R5
  AST_READBACK_FILL: assert property (@(posedge clk) disable iff (rst) readback |=> chain == $past(cfg_out)); // R6
  AST_SCRUB_REPAIRS: assert property (@(posedge clk) disable iff (rst) !upset_en |=> !mismatch); // R7
  AST_ERR_CAUSED: assert property (@(posedge clk) disable iff (rst) err_pulse |-> $past(upset_en, 2)); // R8

endmodule

// File: tb/tb_cfg_column_tmr.sv
module tb_cfg_column_tmr;
  localparam int NP = 4;
  localparam int PB = 8;
  localparam int N  = NP * PB;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0, ser_in = 1'b0, load = 1'b0, readback = 1'b0, upset_en = 1'b0;
  logic [1:0] upset_copy = 2'd3;
  logic [IW-1:0] upset_idx = '0;
  logic ser_out, err_pulse;
  logic [N-1:0] cfg_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cfg_column_tmr #(.NUM_PIXELS(NP), .PIXEL_BITS(PB)) dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out),
    .load(load), .readback(readback), .upset_en(upset_en), .upset_copy(upset_copy),
    .upset_idx(upset_idx), .cfg_out(cfg_out), .err_pulse(err_pulse));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pattern(input int seed);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ((i * 7 + seed * 3 + (i / 5) * seed) % 4) < 2;
    return v;
  endfunction

  task automatic shift_in(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) begin
      ser_in = v[i]; shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic pulse_load();
    load = 1'b1; @(negedge clk); load = 1'b0;
  endtask

  task automatic read_out(output logic [N-1:0] got);
    readback = 1'b1; @(negedge clk); readback = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      got[i] = ser_out;
      shift_en = 1'b1; @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  initial begin
    logic [N-1:0] a, b, got, held;
    logic s0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(cfg_out == '0 && !ser_out && !err_pulse, "R1", cfg_out, '0);

    // R2 R4 R6: several patterns loaded and read back
    for (int p = 0; p < 6; p++) begin
      a = (p == 0) ? '1 : (p == 1) ? '0 : pattern(p);
      shift_in(a);
      check(ser_out == a[N-1], "R2", ser_out, a[N-1]);
      pulse_load();
      check(cfg_out == a, "R4", cfg_out, a);
      read_out(got);
      check(got == a, "R6", got, a);
    end

    // R3 hold without shift_en
    a = pattern(11);
    shift_in(a);
    s0 = ser_out;
    repeat (5) @(negedge clk);
    check(ser_out == s0, "R3", ser_out, s0);
    pulse_load();
    check(cfg_out == a, "R3", cfg_out, a);

    // R5 cfg_out unaffected by shifting without load
    held = cfg_out;
    shift_in(pattern(12));
    check(cfg_out == held, "R5", cfg_out, held);
    pulse_load();

    // R7 R8 R9: every copy, every bit
    a = pattern(13);
    shift_in(a);
    pulse_load();
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < N; k++) begin
        upset_en = 1'b1; upset_copy = 2'(c); upset_idx = IW'(k);
        @(negedge clk);
        upset_en = 1'b0; upset_copy = 2'd3;
        check(cfg_out == a && !err_pulse, "R7", cfg_out, a);
        @(negedge clk);
        check(err_pulse == 1'b1, "R8", err_pulse, 1'b1);
        @(negedge clk);
        check(err_pulse == 1'b0 && cfg_out == a, "R8", err_pulse, 1'b0);
        if (k % 8 == 0) begin
          read_out(got);
          check(got == a, "R7", got, a);
        end
      end
    end

    // R9 copy code 3 changes nothing
    for (int k = 0; k < N; k++) begin
      upset_en = 1'b1; upset_copy = 2'd3; upset_idx = IW'(k);
      @(negedge clk);
      upset_en = 1'b0;
      @(negedge clk);
      check(err_pulse == 1'b0 && cfg_out == a, "R9", cfg_out, a);
    end

    // R10 load and readback together swap
    b = pattern(14);
    shift_in(b);
    load = 1'b1; readback = 1'b1;
    @(negedge clk);
    load = 1'b0; readback = 1'b0;
    check(cfg_out == b, "R10", cfg_out, b);
    got = '0;
    for (int i = N - 1; i >= 0; i--) begin
      got[i] = ser_out;
      shift_en = 1'b1; @(negedge clk);
    end
    shift_en = 1'b0;
    check(got == a, "R10", got, a);

    // R1 reset again after activity
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(cfg_out == '0 && !ser_out && !err_pulse, "R1", cfg_out, '0);

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule